// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block is a small stack-machine core. It takes a stream of zero-address instructions, one per cycle, and works on an internal operand stack that holds up to eight 16-bit words. Arithmetic instructions name no operand. They combine the two uppermost stack entries and leave one result in their place. Memory is reached only through two instructions, one that fetches a word onto the stack and one that stores the top word back, and each of these names a word address. The data memory is a register array with a side load port. Before a program runs, the surrounding logic fills that memory with its input values through the load port.

Each store from the stack is reported on a registered store port, so a host can follow the results a program writes. A halt instruction freezes the core. It raises a sticky done flag and presents the value then on top of the stack. Two sticky flags record a fetch attempted onto a full stack and an operation that found too few entries. In either case the instruction leaves the stack untouched.

Top module: `stk_exec_core`

## Requirements
- R1: After synchronous reset, depth is 0, the overflow flag, the underflow flag, done and st_valid are all 0.
- R2: An instruction word holds the opcode in bits [10:8] and an address in bits [7:0]. Opcode 0 (fetch) places the memory word at the address on top of the stack and raises depth by one, visible after the accepting clock edge.
- R3: Opcode 1 (store) writes the top word to memory at the address and lowers depth by one. In the cycle after it is accepted, st_valid is 1 for exactly one cycle, with st_addr equal to the address and st_data equal to the stored word.
- R4: Opcode 2 replaces the two uppermost entries with their sum modulo 2^16 and lowers depth by one.
- R5: Opcode 3 replaces the two uppermost entries with the lower entry minus the top entry, modulo 2^16.
- R6: Opcode 4 replaces the two uppermost entries with the low 16 bits of their product.
- R7: A fetch at depth 8 sets the sticky overflow flag and leaves depth and every stack entry unchanged.
- R8: An arithmetic opcode at depth below 2, or a store at depth 0, sets the sticky underflow flag, leaves the stack unchanged and produces no store report.
- R9: Opcode 7 sets done, which stays set until reset. It sets result to the top word, or to 0 when the stack is empty. Every instruction after it has no effect on depth or on the store port.
- R10: Opcodes 5 and 6 have no effect on depth, on the stack contents or on the flags.
- R11: A word written through the load port (ld_en, ld_addr, ld_data) is returned by a later fetch from that address, and a stored word is returned by a later fetch from its address.
- R12: The program fetch A, fetch B, mul, fetch A, fetch C, fetch B, mul, add, sub leaves A*B - (A+C*B) as the single stack entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write ld_data into the data memory |
| ld_addr | input | 8 | Load port word address |
| ld_data | input | 16 | Load port data |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_word | input | 11 | Opcode [10:8], address [7:0] |
| st_valid | output | 1 | A store was executed on the previous edge |
| st_addr | output | 8 | Address of the reported store |
| st_data | output | 16 | Word written by the reported store |
| depth | output | 4 | Number of entries on the stack |
| ovf_flag | output | 1 | Sticky: fetch attempted on a full stack |
| unf_flag | output | 1 | Sticky: too few entries for an operation |
| done | output | 1 | Sticky: halt executed |
| result | output | 16 | Top word captured at halt |

## Verification
The hardest case to reach from the ports is a refused fetch at full depth, because the stack then has to be shown unchanged entry by entry. The stimulus fills all eight slots with distinct preloaded words and issues one more fetch. It then drains the stack through stores, and the scoreboard expects the original eight words in reverse order. Each store expectation is queued before its instruction is issued, so any missing, extra or wrong store report is caught, including stores that underflow and must stay silent.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [2:0] OPC_FETCH = 3'd0;
  localparam logic [2:0] OPC_STORE = 3'd1;
  localparam logic [2:0] OPC_ADD   = 3'd2;
  localparam logic [2:0] OPC_SUB   = 3'd3;
  localparam logic [2:0] OPC_MUL   = 3'd4;
  localparam logic [2:0] OPC_HALT  = 3'd7;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_MUL = 2'd2
  } alu_op_e;

  typedef struct packed {
    logic    do_fetch;
    logic    do_store;
    logic    do_alu;
    logic    do_halt;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_pkg::*;
#(
  parameter int OPC_W = 3
) (
  input  logic             valid,
  input  logic             halted,
  input  logic [OPC_W-1:0] opcode,
  output ctrl_t            ctrl
);

  always_comb begin
    ctrl = '{do_fetch: 1'b0, do_store: 1'b0, do_alu: 1'b0,
             do_halt: 1'b0, alu_op: ALU_ADD};
    if (valid && !halted) begin
      // opcodes 5 and 6 fall through as no-ops (R10)
      unique case (opcode)
        OPC_FETCH: ctrl.do_fetch = 1'b1;
        OPC_STORE: ctrl.do_store = 1'b1;
        OPC_ADD:   begin ctrl.do_alu = 1'b1; ctrl.alu_op = ALU_ADD; end
        OPC_SUB:   begin ctrl.do_alu = 1'b1; ctrl.alu_op = ALU_SUB; end
        OPC_MUL:   begin ctrl.do_alu = 1'b1; ctrl.alu_op = ALU_MUL; end
        OPC_HALT:  ctrl.do_halt = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] lower,
  input  logic [DATA_W-1:0] upper,
  output logic [DATA_W-1:0] y
);

  // Operand order: the entry beneath the top is the left operand.
  always_comb begin
    unique case (op)
      ALU_ADD: y = lower + upper;
      ALU_SUB: y = lower - upper;
      ALU_MUL: y = lower * upper;   // self-determined width keeps the low half
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/stk_lifo.sv
module stk_lifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  input  logic              fold_en,
  input  logic [DATA_W-1:0] fold_data,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] below,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              has_two
);

  logic [DEPTH-1:0][DATA_W-1:0] slot_q;
  logic [PTR_W-1:0]             top_idx;
  logic [PTR_W-1:0]             below_idx;

  // One register per stack slot; a slot loads on a push into it or on
  // a fold that lands the result in it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (push_en && count == CNT_W'(i))
        q <= push_data;
      else if (fold_en && count == CNT_W'(i + 2))
        q <= fold_data;
    end
    assign slot_q[i] = q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (push_en)
      count <= count + CNT_W'(1);
    else if (pop_en || fold_en)
      count <= count - CNT_W'(1);
  end

  assign top_idx   = PTR_W'(count - CNT_W'(1));
  assign below_idx = PTR_W'(count - CNT_W'(2));
  assign top       = slot_q[top_idx];
  assign below     = slot_q[below_idx];
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign has_two   = (count >= CNT_W'(2));

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
    push_en |=> count == $past(count) + CNT_W'(1)); // R2
  AST_PUSH_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    push_en |=> top == $past(push_data)); // R2
  AST_FOLD_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (fold_en || pop_en) |=> count == $past(count) - CNT_W'(1)); // R4
  AST_FOLD_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    fold_en |=> top == $past(fold_data)); // R4

endmodule

// File: rtl/stk_dmem.sv
module stk_dmem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  // Asynchronous read: a fetch completes in the cycle it is accepted.
  assign rdata = mem[raddr];

endmodule

// File: rtl/stk_exec_core.sv
module stk_exec_core
  import stk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  parameter int OPC_W  = 3,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int INS_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              instr_valid,
  input  logic [INS_W-1:0]  instr_word,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic [CNT_W-1:0]  depth,
  output logic              ovf_flag,
  output logic              unf_flag,
  output logic              done,
  output logic [DATA_W-1:0] result
);

  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] iaddr;
  ctrl_t             ctrl;

  logic [DATA_W-1:0] top, below, alu_y, mem_rdata;
  logic              full, empty, has_two;

  logic fetch_ok, fetch_bad, store_ok, store_bad, alu_ok, alu_bad;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign opcode = instr_word[ADDR_W +: OPC_W];
  assign iaddr  = instr_word[ADDR_W-1:0];

  stk_decode #(.OPC_W(OPC_W)) u_decode (
    .valid  (instr_valid),
    .halted (done),
    .opcode (opcode),
    .ctrl   (ctrl)
  );

  assign fetch_ok  = ctrl.do_fetch && !full;
  assign fetch_bad = ctrl.do_fetch && full;
  assign store_ok  = ctrl.do_store && !empty;
  assign store_bad = ctrl.do_store && empty;
  assign alu_ok    = ctrl.do_alu && has_two;
  assign alu_bad   = ctrl.do_alu && !has_two;

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (ctrl.alu_op),
    .lower (below),
    .upper (top),
    .y     (alu_y)
  );

  stk_lifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_lifo (
    .clk       (clk),
    .rst       (rst),
    .push_en   (fetch_ok),
    .push_data (mem_rdata),
    .pop_en    (store_ok),
    .fold_en   (alu_ok),
    .fold_data (alu_y),
    .top       (top),
    .below     (below),
    .count     (depth),
    .full      (full),
    .empty     (empty),
    .has_two   (has_two)
  );

  // A store issued by the program takes the single write port ahead of
  // the side load port.
  assign mem_we    = store_ok || ld_en;
  assign mem_waddr = store_ok ? iaddr : ld_addr;
  assign mem_wdata = store_ok ? top   : ld_data;

  stk_dmem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dmem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (iaddr),
    .rdata (mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_addr  <= '0;
      st_data  <= '0;
      ovf_flag <= 1'b0;
      unf_flag <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
    end else begin
      st_valid <= store_ok;
      if (store_ok) begin
        st_addr <= iaddr;
        st_data <= top;
      end
      if (fetch_bad)
        ovf_flag <= 1'b1;
      if (store_bad || alu_bad)
        unf_flag <= 1'b1;
      if (ctrl.do_halt) begin
        done   <= 1'b1;
        result <= empty ? '0 : top;
      end
    end
  end

  AST_FULL_FETCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    fetch_bad |=> ovf_flag && depth == $past(depth)); // R7
  AST_SHORT_ALU_HOLDS: assert property (@(posedge clk) disable iff (rst)
    alu_bad |=> unf_flag && $stable(depth)); // R8
  AST_EMPTY_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
    store_bad |=> unf_flag && !st_valid); // R8
  AST_STORE_REPORT: assert property (@(posedge clk) disable iff (rst)
    store_ok |=> st_valid && st_addr == $past(iaddr)); // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R9
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    done |=> $stable(depth) && !st_valid); // R9

endmodule

// File: tb/stk_exec_core_test.sv
module stk_exec_core_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic        instr_valid = 1'b0;
  logic [10:0] instr_word = '0;
  logic        st_valid;
  logic [7:0]  st_addr;
  logic [15:0] st_data;
  logic [3:0]  depth;
  logic        ovf_flag, unf_flag, done;
  logic [15:0] result;

  int total = 0;
  int fails = 0;
  logic [23:0] exp_q [$];   // {addr, data} of each expected store

  always #(CLK_PERIOD / 2) clk = ~clk;

  stk_exec_core uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .instr_valid(instr_valid), .instr_word(instr_word),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .depth(depth), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .done(done), .result(result)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: every store report is matched against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && st_valid) begin
      if (exp_q.size() == 0) begin
        chk("R8 unexpected store", {8'h0, st_addr, st_data}, 32'hFFFF_FFFF);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk("R3 store report", {8'h0, st_addr, st_data}, {8'h0, e});
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; instr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] a);
    @(negedge clk);
    instr_valid = 1'b1; instr_word = {op, a};
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  // Driver for stores: queue the expectation, then issue the instruction.
  task automatic store_expect(logic [7:0] a, logic [15:0] d);
    exp_q.push_back({a, d});
    issue(3'd1, a);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 depth", 32'(depth), 0);
    chk("R1 flags", {29'h0, ovf_flag, unf_flag, done}, 0);
    chk("R1 st_valid", 32'(st_valid), 0);

    load(8'h10, 16'd3); load(8'h11, 16'd5); load(8'h12, 16'd7);
    load(8'h20, 16'hFFFF); load(8'h21, 16'h1234); load(8'h22, 16'h0010);
    for (int i = 0; i < 8; i++) load(8'h40 + 8'(i), 16'(i + 1));

    // R12 expression A*B - (A+C*B) with A=3 B=5 C=7 -> 15-38 = 0xFFE9
    issue(3'd0, 8'h10);
    chk("R2 depth after fetch", 32'(depth), 1);
    issue(3'd0, 8'h11); issue(3'd4, 8'h00);
    issue(3'd0, 8'h10); issue(3'd0, 8'h12); issue(3'd0, 8'h11);
    chk("R2 depth 4", 32'(depth), 4);
    issue(3'd4, 8'h00); issue(3'd2, 8'h00); issue(3'd3, 8'h00);
    chk("R12 single entry", 32'(depth), 1);
    store_expect(8'h30, 16'hFFE9);   // R12 value
    chk("R3 depth after store", 32'(depth), 0);

    // R11: stored word read back, then stored again
    issue(3'd0, 8'h30);
    store_expect(8'h31, 16'hFFE9);

    // R4 add wraps
    issue(3'd0, 8'h20); issue(3'd0, 8'h10); issue(3'd2, 8'h00);
    chk("R4 depth", 32'(depth), 1);
    store_expect(8'h32, 16'h0002);

    // R5 lower minus top: 5 - 7
    issue(3'd0, 8'h11); issue(3'd0, 8'h12); issue(3'd3, 8'h00);
    store_expect(8'h33, 16'hFFFE);

    // R6 low half of 0x1234 * 0x0010
    issue(3'd0, 8'h21); issue(3'd0, 8'h22); issue(3'd4, 8'h00);
    store_expect(8'h34, 16'h2340);
    chk("R1 no flags so far", {30'h0, ovf_flag, unf_flag}, 0);

    // R8 underflow cases
    do_reset();
    issue(3'd2, 8'h00);
    chk("R8 unf on empty add", 32'(unf_flag), 1);
    chk("R8 depth unchanged", 32'(depth), 0);
    issue(3'd1, 8'h35);               // store on empty: no report
    chk("R8 depth after empty store", 32'(depth), 0);
    issue(3'd0, 8'h10); issue(3'd3, 8'h00);
    chk("R8 depth with one entry", 32'(depth), 1);
    chk("R8 no overflow", 32'(ovf_flag), 0);
    store_expect(8'h35, 16'd3);

    // R7 overflow leaves stack intact
    do_reset();
    for (int i = 0; i < 8; i++) issue(3'd0, 8'h40 + 8'(i));
    chk("R7 full depth", 32'(depth), 8);
    chk("R7 no flag yet", 32'(ovf_flag), 0);
    issue(3'd0, 8'h10);
    chk("R7 ovf set", 32'(ovf_flag), 1);
    chk("R7 depth held", 32'(depth), 8);
    for (int i = 0; i < 8; i++) store_expect(8'h50 + 8'(i), 16'(8 - i));
    chk("R7 drained", 32'(depth), 0);
    chk("R7 ovf sticky", 32'(ovf_flag), 1);

    // R10 opcodes 5 and 6 do nothing
    do_reset();
    issue(3'd0, 8'h10);
    issue(3'd5, 8'h00); issue(3'd6, 8'h36);
    chk("R10 depth", 32'(depth), 1);
    chk("R10 flags", {30'h0, ovf_flag, unf_flag}, 0);
    store_expect(8'h36, 16'd3);

    // R9 halt with two entries, then ignored instructions
    do_reset();
    issue(3'd0, 8'h11); issue(3'd0, 8'h12); issue(3'd7, 8'h00);
    chk("R9 done", 32'(done), 1);
    chk("R9 result top", 32'(result), 7);
    issue(3'd0, 8'h10); issue(3'd1, 8'h37);
    chk("R9 depth frozen", 32'(depth), 2);
    chk("R9 done sticky", 32'(done), 1);

    // R9 halt on empty stack
    do_reset();
    chk("R1 done cleared", 32'(done), 0);
    issue(3'd7, 8'h00);
    chk("R9 empty result", 32'(result), 0);

    repeat (3) @(negedge clk);
    chk("R3 all stores seen", 32'(exp_q.size()), 0);
    report();
    $finish;
  end

endmodule